// File: doc/BRIEF.md
# Four-Channel Time-Shared Sine/Cosine Oscillator

This block generates sine and cosine samples for four independent frequencies from a single phase-to-amplitude path. A channel counter visits the channels once each in the order 0, 1, 2, 3, 0, … at one channel per clock. On each visit the selected channel's 24-bit phase accumulator is sampled and then advanced by that channel's own phase increment. The sampled phase is truncated to 10 bits and looked up in a 256-entry quarter-wave table. The result leaves the block as a signed 18-bit sample with 17 fraction bits, together with a valid flag and a 2-bit channel tag.

A processor programs the four increments through a write-only register port. Channel c sits at word address c, counting from a base of zero. The block stays idle until the first clock on which the input valid is seen high. From then on it free-runs, and its tagged output valid can start the next stage in a chain without any global controller. One full turn of the unit circle is 2^24 accumulator counts. For example, an increment of about 2^24/5.95 at a 61.44 MHz sample rate gives a tone near 10.32 MHz.

Top module: `tdm_nco`

## Requirements
- R1: While reset is high at a clock edge, every accumulator clears to zero and channel c's increment loads (INC_BASE·(c+1)) mod 2^24, with INC_BASE = 2819700. During reset, out_valid, out_chan, out_sin and out_cos read zero.
- R2: Suppose in_valid is first sampled high at clock edge k after reset. Then out_valid first reads 1 after edge k+2 and stays 1 on every later cycle, whatever in_valid does afterwards. Before that point out_valid is 0.
- R3: Successive valid outputs carry out_chan 0, 1, 2, 3, 0, …, and the first valid output has channel 0.
- R4: Each output uses the channel's accumulator value from before its visit. The accumulator then gains that channel's increment, so channel c's n-th output uses phase n·inc while inc stays constant.
- R5: Let p be the top 10 bits of the sampled phase and A = 131071. Then out_sin = round(A·sin(2π(p+0.5)/1024)) and out_cos = round(A·cos(2π(p+0.5)/1024)). Rounding is half away from zero, and the outputs are signed two's complement with 17 fraction bits.
- R6: The outputs never take the value −131072, and they read zero while out_valid is 0.
- R7: A write with reg_wr_en high and reg_addr = c (0..3) loads reg_wdata[23:0] as channel c's increment. If the same edge also advances channel c, that advance still uses the old increment. The new value applies from the next visit onward.
- R8: Writes to addresses 4 to 15 change no increment and no output.
- R9: Accumulators wrap modulo 2^24. For example, an increment of 0xFFFFFF steps the phase backwards by one count.
- R10: Increment writes are accepted before the start, and the first samples use them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input valid; the first high sample starts the block |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 24 | Increment value to write |
| out_valid | output | 1 | Output sample valid |
| out_chan | output | 2 | Channel index of the current sample |
| out_sin | output | 18 | Signed sine sample, 17 fraction bits |
| out_cos | output | 18 | Signed cosine sample, 17 fraction bits |

## Verification
The bench builds the block with its default parameters: four channels, a 24-bit accumulator, a 10-bit lookup phase and 18-bit outputs. With a one-quarter-turn increment, all four quadrants of the table, including the reflected addresses and negated halves, are reached within a few visits. With an all-ones increment, the accumulator wraps backwards through zero on the first visit. The 4-bit address leaves twelve unused addresses to probe. Because a channel comes around every four cycles, a mid-run write lands at each possible distance from that channel's next visit.

// File: rtl/nco_pkg.sv
package nco_pkg;

    localparam real PI = 3.14159265358979323846;

    typedef logic [1:0] quad_t;

    // Magnitude of one quarter-wave entry, sampled at the middle of its step.
    function automatic int qw_mag(input int idx, input int quarter_len, input int amp);
        real th;
        th = (PI / 2.0) * (real'(idx) + 0.5) / real'(quarter_len);
        return $rtoi(real'(amp) * $sin(th) + 0.5);
    endfunction

endpackage

// File: rtl/nco_phase_bank.sv
module nco_phase_bank #(
    parameter int NUM_CH   = 4,
    parameter int ACC_W    = 24,
    parameter int PH_W     = 10,
    parameter int ADDR_W   = 4,
    parameter int INC_BASE = 2819700,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ACC_W-1:0]  wr_data,
    output logic              ph_valid,
    output logic [CH_W-1:0]   ph_chan,
    output logic [PH_W-1:0]   ph_phase
);

    typedef struct packed {
        logic                          run;
        logic [CH_W-1:0]               ch;
        logic [NUM_CH-1:0][ACC_W-1:0]  acc;
        logic [NUM_CH-1:0][ACC_W-1:0]  inc;
        logic                          pv;
        logic [CH_W-1:0]               pch;
        logic [PH_W-1:0]               pph;
    } bank_t;

    bank_t st_d, st_q;

    function automatic logic [ACC_W-1:0] inc_default(input int c);
        longint v;
        v = longint'(INC_BASE) * longint'(c + 1);
        return ACC_W'(v);
    endfunction

    always_comb begin
        st_d = st_q;

        // Visit the current channel: sample its phase, then advance it.
        st_d.pv  = st_q.run;
        st_d.pch = '0;
        st_d.pph = '0;
        if (st_q.run) begin
            st_d.pch = st_q.ch;
            st_d.pph = st_q.acc[st_q.ch][ACC_W-1 -: PH_W];
            st_d.acc[st_q.ch] = st_q.acc[st_q.ch] + st_q.inc[st_q.ch];
            if (st_q.ch == CH_W'(NUM_CH - 1)) begin
                st_d.ch = '0;
            end else begin
                st_d.ch = st_q.ch + CH_W'(1);
            end
        end

        // First observed valid starts the round robin.
        if (!st_q.run && in_valid) begin
            st_d.run = 1'b1;
        end

        // Increment writes; addresses past the last channel fall through.
        for (int c = 0; c < NUM_CH; c++) begin
            if (wr_en && (wr_addr == ADDR_W'(c))) begin
                st_d.inc[c] = wr_data;
            end
        end

        if (rst) begin
            st_d.run = 1'b0;
            st_d.ch  = '0;
            st_d.acc = '0;
            st_d.pv  = 1'b0;
            st_d.pch = '0;
            st_d.pph = '0;
            for (int c = 0; c < NUM_CH; c++) begin
                st_d.inc[c] = inc_default(c);
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ph_valid = st_q.pv;
    assign ph_chan  = st_q.pch;
    assign ph_phase = st_q.pph;

endmodule

// File: rtl/nco_qwave_rom.sv
module nco_qwave_rom #(
    parameter int TAB_AW = 8,
    parameter int MAG_W  = 17,
    localparam int DEPTH = 1 << TAB_AW,
    localparam int AMP   = (1 << MAG_W) - 1
) (
    input  logic [TAB_AW-1:0] addr,
    output logic [MAG_W-1:0]  mag
);

    logic [MAG_W-1:0] rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        localparam int VAL = nco_pkg::qw_mag(g, DEPTH, AMP);
        assign rom[g] = MAG_W'(VAL);
    end

    assign mag = rom[addr];

endmodule

// File: rtl/nco_sincos_map.sv
module nco_sincos_map #(
    parameter int PH_W   = 10,
    parameter int OUT_W  = 18,
    localparam int TAB_AW = PH_W - 2,
    localparam int MAG_W  = OUT_W - 1
) (
    input  logic [PH_W-1:0]         phase,
    output logic signed [OUT_W-1:0] value
);

    nco_pkg::quad_t      quad;
    logic [TAB_AW-1:0]   idx;
    logic [TAB_AW-1:0]   tab_addr;
    logic [MAG_W-1:0]    mag;
    logic signed [OUT_W-1:0] pos;

    assign quad = phase[PH_W-1 -: 2];
    assign idx  = phase[TAB_AW-1:0];

    // Odd quadrants read the table mirrored; the upper half is negated.
    assign tab_addr = quad[0] ? ~idx : idx;

    nco_qwave_rom #(
        .TAB_AW (TAB_AW),
        .MAG_W  (MAG_W)
    ) i_rom (
        .addr (tab_addr),
        .mag  (mag)
    );

    assign pos   = $signed({1'b0, mag});
    assign value = quad[1] ? -pos : pos;

endmodule

// File: rtl/tdm_nco.sv
module tdm_nco #(
    parameter int NUM_CH   = 4,
    parameter int ACC_W    = 24,
    parameter int PH_W     = 10,
    parameter int OUT_W    = 18,
    parameter int ADDR_W   = 4,
    parameter int INC_BASE = 2819700,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic                    reg_wr_en,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [ACC_W-1:0]        reg_wdata,
    output logic                    out_valid,
    output logic [CH_W-1:0]         out_chan,
    output logic signed [OUT_W-1:0] out_sin,
    output logic signed [OUT_W-1:0] out_cos
);

    localparam logic [PH_W-1:0] QUARTER = PH_W'(1 << (PH_W - 2));

    typedef struct packed {
        logic                    ov;
        logic [CH_W-1:0]         och;
        logic signed [OUT_W-1:0] osin;
        logic signed [OUT_W-1:0] ocos;
    } out_t;

    logic            ph_valid;
    logic [CH_W-1:0] ph_chan;
    logic [PH_W-1:0] ph_phase;
    logic [PH_W-1:0] lut_phase [2];
    logic signed [OUT_W-1:0] lut_val [2];

    out_t out_d, out_q;

    nco_phase_bank #(
        .NUM_CH   (NUM_CH),
        .ACC_W    (ACC_W),
        .PH_W     (PH_W),
        .ADDR_W   (ADDR_W),
        .INC_BASE (INC_BASE)
    ) i_bank (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .wr_en    (reg_wr_en),
        .wr_addr  (reg_addr),
        .wr_data  (reg_wdata),
        .ph_valid (ph_valid),
        .ph_chan  (ph_chan),
        .ph_phase (ph_phase)
    );

    // Path 0 gives the sine; path 1 is shifted a quarter turn for the cosine.
    assign lut_phase[0] = ph_phase;
    assign lut_phase[1] = ph_phase + QUARTER;

    for (genvar k = 0; k < 2; k++) begin : g_path
        nco_sincos_map #(
            .PH_W  (PH_W),
            .OUT_W (OUT_W)
        ) i_map (
            .phase (lut_phase[k]),
            .value (lut_val[k])
        );
    end

    always_comb begin
        out_d.ov   = ph_valid;
        out_d.och  = ph_valid ? ph_chan    : '0;
        out_d.osin = ph_valid ? lut_val[0] : '0;
        out_d.ocos = ph_valid ? lut_val[1] : '0;
        if (rst) begin
            out_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        out_q <= out_d;
    end

    assign out_valid = out_q.ov;
    assign out_chan  = out_q.och;
    assign out_sin   = out_q.osin;
    assign out_cos   = out_q.ocos;

endmodule

// File: rtl/tdm_nco_chk.sv
module tdm_nco_chk #(
    parameter int NUM_CH = 4,
    parameter int OUT_W  = 18,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam longint AMP = (longint'(1) << (OUT_W - 1)) - 1
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic                    out_valid,
    input logic [CH_W-1:0]         out_chan,
    input logic signed [OUT_W-1:0] out_sin,
    input logic signed [OUT_W-1:0] out_cos
);

    localparam logic signed [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};

    logic   armed_q = 1'b0;
    logic   seen_q  = 1'b0;
    longint pow2;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b1;
            seen_q  <= 1'b0;
        end else if (in_valid) begin
            seen_q  <= 1'b1;
        end
    end

    always_comb begin
        pow2 = longint'(out_sin) * longint'(out_sin) + longint'(out_cos) * longint'(out_cos);
    end

    p_no_early_valid_r2: assert property (@(posedge clk) disable iff (rst || !armed_q)
        !seen_q |-> !out_valid);

    p_valid_sticky_r2: assert property (@(posedge clk) disable iff (rst || !armed_q)
        $past(out_valid) |-> out_valid);

    p_chan_order_r3: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (out_valid && $past(out_valid)) |->
            (out_chan == (($past(out_chan) == CH_W'(NUM_CH - 1)) ? '0 : $past(out_chan) + CH_W'(1))));

    p_unit_circle_r5: assert property (@(posedge clk) disable iff (rst || !armed_q)
        out_valid |-> (pow2 >= (AMP - 2) * (AMP - 2) && pow2 <= (AMP + 1) * (AMP + 1)));

    p_symmetric_clip_r6: assert property (@(posedge clk) disable iff (rst || !armed_q)
        out_valid |-> (out_sin != MOST_NEG && out_cos != MOST_NEG));

    p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst || !armed_q)
        !out_valid |-> (out_sin == '0 && out_cos == '0));

endmodule

bind tdm_nco tdm_nco_chk #(
    .NUM_CH (NUM_CH),
    .OUT_W  (OUT_W)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_chan  (out_chan),
    .out_sin   (out_sin),
    .out_cos   (out_cos)
);

// File: tb/test_tdm_nco.sv
module test_tdm_nco;

    localparam int  CLK_PERIOD = 10;
    localparam int  WATCHDOG   = 5000;
    localparam int  INC_BASE   = 2819700;
    localparam int  MASK24     = 24'hFFFFFF;
    localparam real TWO_PI     = 6.28318530717958647692;
    localparam real AMP        = 131071.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [23:0] reg_wdata = '0;
    logic        out_valid;
    logic [1:0]  out_chan;
    logic signed [17:0] out_sin;
    logic signed [17:0] out_cos;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string cur_tag = "R1";

    // Reference model state
    int m_acc [4];
    int m_inc [4];
    bit m_run;
    int m_ch;
    bit s1_v;
    int s1_ch;
    int s1_p;
    bit e_v;
    int e_ch;
    int e_sin;
    int e_cos;

    tdm_nco i_tdm_nco (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .reg_wr_en (reg_wr_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .out_valid (out_valid),
        .out_chan  (out_chan),
        .out_sin   (out_sin),
        .out_cos   (out_cos)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int round_away(input real v);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(-v + 0.5);
    endfunction

    function automatic int wave(input int p, input bit use_cos);
        real th;
        th = TWO_PI * (real'(p) + 0.5) / 1024.0;
        return use_cos ? round_away(AMP * $cos(th)) : round_away(AMP * $sin(th));
    endfunction

    // Behavioural model, advanced on the same edges as the design.
    always @(posedge clk) begin
        if (rst) begin
            m_run = 0; m_ch = 0; s1_v = 0; s1_ch = 0; s1_p = 0;
            e_v = 0; e_ch = 0; e_sin = 0; e_cos = 0;
            for (int c = 0; c < 4; c++) begin
                m_acc[c] = 0;
                m_inc[c] = (INC_BASE * (c + 1)) & MASK24;
            end
        end else begin
            e_v   = s1_v;
            e_ch  = s1_v ? s1_ch : 0;
            e_sin = s1_v ? wave(s1_p, 1'b0) : 0;
            e_cos = s1_v ? wave(s1_p, 1'b1) : 0;
            s1_v  = m_run;
            if (m_run) begin
                s1_ch = m_ch;
                s1_p  = m_acc[m_ch] >> 14;
                m_acc[m_ch] = (m_acc[m_ch] + m_inc[m_ch]) & MASK24;
                m_ch = (m_ch + 1) % 4;
            end
            if (!m_run && in_valid) m_run = 1;
            if (reg_wr_en && reg_addr < 4) m_inc[reg_addr] = int'(reg_wdata);
        end
    end

    task automatic check_int(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0d expected %0d at %0t", tag, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            check_int(rst ? "R1" : "R2", "out_valid", int'(out_valid), int'(e_v));
            check_int(rst ? "R1" : "R3", "out_chan", int'(out_chan), e_ch);
            check_int(cur_tag, "out_sin", int'(out_sin), e_sin);
            check_int(cur_tag, "out_cos", int'(out_cos), e_cos);
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_reg(input logic [3:0] a, input logic [23:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        cur_tag = "R1";
        idle(4);
        rst = 1'b0;
        // R2: idle without valid, outputs stay low and zero (R6)
        cur_tag = "R6";
        idle(6);
        // R10: program before start; R9 backwards wrap on channel 2
        cur_tag = "R10";
        write_reg(4'd0, 24'h400000);
        write_reg(4'd2, 24'hFFFFFF);
        idle(2);
        // R2: start, then drop valid; block keeps running
        cur_tag = "R4";
        @(negedge clk);
        in_valid = 1'b1;
        idle(3);
        in_valid = 1'b0;
        cur_tag = "R9";
        idle(40);
        // R8: unused addresses
        cur_tag = "R8";
        write_reg(4'd5, 24'h000001);
        write_reg(4'd9, 24'hABCDEF);
        write_reg(4'd15, 24'h7FFFFF);
        idle(20);
        // R7: mid-run writes at different offsets from the channel's visit
        cur_tag = "R7";
        write_reg(4'd1, 24'h123456);
        idle(1);
        write_reg(4'd3, 24'h000000);
        idle(2);
        write_reg(4'd0, 24'h0A0000);
        idle(40);
        // R5: large steps across all quadrants
        cur_tag = "R5";
        write_reg(4'd2, 24'h3C4000);
        write_reg(4'd1, 24'hC00000);
        idle(60);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule